// File: doc/BRIEF.md
# Hashed Page Table Group Index Generator

This block turns a translation request into the two candidate locations of a hashed page table. A request carries a virtual segment identifier, an effective address, a two-bit segment-size code and a page-size shift. The block builds the virtual page number in 4 KB units, folds it into a 39-bit hash, and forms a primary and a secondary hash. Both are trimmed by a hash mask, and the block turns each one into the byte address of an eight-entry group by scaling it and adding it to a table base.

Requests enter through a valid/ready port and results leave through another. A request is taken on a rising edge when `in_valid` and `in_ready` are both high. A result is handed over on an edge when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output holds its value. A two-deep pipeline absorbs the stall before `in_ready` drops, and with `out_ready` held high the block takes one request on every cycle. The table base and hash mask are plain configuration pins, but they are captured together with each request, so they may change freely while earlier requests are in flight.

Top module: `hpt_index_gen`

## Requirements
- R1: With segment code 0 (256 MB), the VPN is `(vsid << 16) | ea[27:12]`, truncated to VPN_W bits.
- R2: With segment code 1 (1 TB), the VPN is `(vsid << 28) | ea[39:12]`, truncated to VPN_W bits.
- R3: With segment code 0, the raw hash is the low 39 bits of `(vpn >> 16) ^ (vpn[15:0] >> off)`, where `off` is the page shift minus 12.
- R4: With segment code 1, let `v = vpn >> 28`. The raw hash is the low 39 bits of `v ^ (v << 25) ^ (vpn[27:0] >> off)`. Bits shifted above bit 38 are lost.
- R5: A page shift of 12 or less gives `off = 0`. Larger shifts drop the low `page_shift - 12` bits of the page index before it is XORed in.
- R6: `out_hash_pri` equals the raw hash ANDed with the mask. `out_hash_sec` equals the complement of the raw hash ANDed with the mask.
- R7: `out_pteg_pri` is `base + (out_hash_pri << 7)` and `out_pteg_sec` is `base + (out_hash_sec << 7)`, since a group is 8 entries of 16 bytes.
- R8: Segment codes 2 and 3 are reserved. For these codes `out_seg_err` is 1 and the result is computed by the 256 MB rules. For codes 0 and 1 `out_seg_err` is 0.
- R9: While `out_valid` is high and `out_ready` is low, all outputs hold. When two results are waiting, `in_ready` is low.
- R10: An accepted request shows on the outputs after the second rising edge that follows acceptance, if the output is not stalled. With `out_ready` held high, the block takes and delivers one request per cycle, in order.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.
- R12: The base and mask used for a result are the values present on the edge where its request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_vsid | input | VSID_W | Virtual segment identifier |
| in_ea | input | EA_W | Effective address |
| in_seg | input | 2 | Segment code: 0 = 256 MB, 1 = 1 TB, 2 and 3 reserved |
| in_page_shift | input | PS_W | Log2 of the page size |
| cfg_base | input | ADDR_W | Table base address |
| cfg_hash_mask | input | 39 | Hash mask |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_vpn | output | VPN_W | Virtual page number in 4 KB units |
| out_hash_pri | output | 39 | Masked primary hash |
| out_hash_sec | output | 39 | Masked secondary hash |
| out_pteg_pri | output | ADDR_W | Primary group address |
| out_pteg_sec | output | ADDR_W | Secondary group address |
| out_seg_err | output | 1 | Reserved segment code seen |

## Verification
A result is due after the second rising edge that follows its acceptance. The bench drives at falling edges and looks for `out_valid` low at the falling edge after acceptance and high at the next one, where it compares every field. In the stall test the bench keeps `out_ready` low and samples the held outputs and `in_ready` at several falling edges. It then releases `out_ready` and expects the two queued results on two consecutive falling edges. To show that configuration is captured per request, the bench changes the base and mask one cycle after acceptance, before the result is due.

// File: rtl/hpt_pkg.sv
`timescale 1ns/1ps
package hpt_pkg;
  localparam int HASH_W     = 39;  // hash width kept after folding
  localparam int UNIT_SH    = 12;  // VPN unit is 4 KB
  localparam int SEG_SH_S   = 28;  // 256 MB segment
  localparam int SEG_SH_L   = 40;  // 1 TB segment
  localparam int IDX_S      = SEG_SH_S - UNIT_SH;  // 16 page-index bits
  localparam int IDX_L      = SEG_SH_L - UNIT_SH;  // 28 page-index bits
  localparam int FOLD_SH    = 25;  // self-fold shift of the large form
  localparam int GRP_LOG2   = 7;   // 8 entries x 16 bytes

  typedef enum logic [1:0] {
    SEG_SMALL = 2'd0,
    SEG_LARGE = 2'd1,
    SEG_RSV_A = 2'd2,
    SEG_RSV_B = 2'd3
  } seg_code_e;
endpackage

// File: rtl/hpt_stage.sv
`timescale 1ns/1ps
module hpt_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end
endmodule

// File: rtl/hpt_vpn_form.sv
`timescale 1ns/1ps
module hpt_vpn_form
  import hpt_pkg::*;
#(
  parameter int VSID_W = 50,
  parameter int EA_W   = 64,
  parameter int VPN_W  = 66
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [EA_W-1:0]   ea,
  input  logic              is_large,
  output logic [VPN_W-1:0]  vpn
);
  localparam int WIDE = VSID_W + IDX_L;

  logic [IDX_L-1:0] pidx;
  logic [WIDE-1:0]  v_small, v_large;

  assign pidx    = ea[UNIT_SH +: IDX_L];
  assign v_small = (WIDE'(vsid) << IDX_S) | WIDE'(pidx[IDX_S-1:0]);
  assign v_large = (WIDE'(vsid) << IDX_L) | WIDE'(pidx);
  assign vpn     = is_large ? VPN_W'(v_large) : VPN_W'(v_small);
endmodule

// File: rtl/hpt_hash_fold.sv
`timescale 1ns/1ps
module hpt_hash_fold
  import hpt_pkg::*;
#(
  parameter int VPN_W = 66,
  parameter int PS_W  = 6
) (
  input  logic [VPN_W-1:0]  vpn,
  input  logic              is_large,
  input  logic [PS_W-1:0]   page_shift,
  output logic [HASH_W-1:0] hash
);
  logic [PS_W-1:0]   off;
  logic [HASH_W-1:0] hi_s, lo_s, hi_l, lo_l, h_s, h_l;

  assign off  = (page_shift <= PS_W'(UNIT_SH)) ? '0 : page_shift - PS_W'(UNIT_SH);

  assign hi_s = HASH_W'(vpn >> IDX_S);
  assign lo_s = HASH_W'(vpn[IDX_S-1:0]) >> off;
  assign h_s  = hi_s ^ lo_s;

  assign hi_l = HASH_W'(vpn >> IDX_L);
  assign lo_l = HASH_W'(vpn[IDX_L-1:0]) >> off;
  assign h_l  = hi_l ^ (hi_l << FOLD_SH) ^ lo_l;

  assign hash = is_large ? h_l : h_s;
endmodule

// File: rtl/hpt_pteg_calc.sv
`timescale 1ns/1ps
module hpt_pteg_calc
  import hpt_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [HASH_W-1:0] raw_hash,
  input  logic [HASH_W-1:0] mask,
  input  logic [ADDR_W-1:0] base,
  output logic [HASH_W-1:0] hash_pri,
  output logic [HASH_W-1:0] hash_sec,
  output logic [ADDR_W-1:0] pteg_pri,
  output logic [ADDR_W-1:0] pteg_sec
);
  logic [1:0][HASH_W-1:0] sel_h;
  logic [1:0][ADDR_W-1:0] sel_a;

  for (genvar g = 0; g < 2; g++) begin : g_way
    logic [HASH_W-1:0] src;
    assign src      = (g == 0) ? raw_hash : ~raw_hash;
    assign sel_h[g] = src & mask;
    assign sel_a[g] = base + (ADDR_W'(sel_h[g]) << GRP_LOG2);
  end

  assign hash_pri = sel_h[0];
  assign hash_sec = sel_h[1];
  assign pteg_pri = sel_a[0];
  assign pteg_sec = sel_a[1];
endmodule

// File: rtl/hpt_index_gen.sv
`timescale 1ns/1ps
module hpt_index_gen
  import hpt_pkg::*;
#(
  parameter int VSID_W = 50,
  parameter int EA_W   = 64,
  parameter int VPN_W  = 66,
  parameter int ADDR_W = 64,
  parameter int PS_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VSID_W-1:0] in_vsid,
  input  logic [EA_W-1:0]   in_ea,
  input  logic [1:0]        in_seg,
  input  logic [PS_W-1:0]   in_page_shift,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [HASH_W-1:0] cfg_hash_mask,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VPN_W-1:0]  out_vpn,
  output logic [HASH_W-1:0] out_hash_pri,
  output logic [HASH_W-1:0] out_hash_sec,
  output logic [ADDR_W-1:0] out_pteg_pri,
  output logic [ADDR_W-1:0] out_pteg_sec,
  output logic              out_seg_err
);
  localparam int AW = 1 + VPN_W + HASH_W + ADDR_W + HASH_W;
  localparam int BW = 1 + VPN_W + 2 * HASH_W + 2 * ADDR_W;

  seg_code_e         seg_c;
  logic              is_large, seg_err;
  logic [VPN_W-1:0]  vpn_in;
  logic [HASH_W-1:0] hash_in;

  assign seg_c    = seg_code_e'(in_seg);
  assign is_large = (seg_c == SEG_LARGE);
  assign seg_err  = (seg_c == SEG_RSV_A) || (seg_c == SEG_RSV_B);

  hpt_vpn_form #(.VSID_W(VSID_W), .EA_W(EA_W), .VPN_W(VPN_W)) u_vpn (
    .vsid(in_vsid), .ea(in_ea), .is_large(is_large), .vpn(vpn_in)
  );

  hpt_hash_fold #(.VPN_W(VPN_W), .PS_W(PS_W)) u_hash (
    .vpn(vpn_in), .is_large(is_large), .page_shift(in_page_shift), .hash(hash_in)
  );

  // stage A: VPN, raw hash and the configuration captured with the request
  logic              a_valid, a_ready;
  logic [AW-1:0]     a_q;
  logic              a_err;
  logic [VPN_W-1:0]  a_vpn;
  logic [HASH_W-1:0] a_hash, a_mask;
  logic [ADDR_W-1:0] a_base;

  hpt_stage #(.W(AW)) u_stage_a (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready),
    .up_data({seg_err, vpn_in, hash_in, cfg_base, cfg_hash_mask}),
    .dn_valid(a_valid), .dn_ready(a_ready), .dn_data(a_q)
  );

  assign {a_err, a_vpn, a_hash, a_base, a_mask} = a_q;

  logic [HASH_W-1:0] b_hp, b_hs;
  logic [ADDR_W-1:0] b_ap, b_as;

  hpt_pteg_calc #(.ADDR_W(ADDR_W)) u_pteg (
    .raw_hash(a_hash), .mask(a_mask), .base(a_base),
    .hash_pri(b_hp), .hash_sec(b_hs), .pteg_pri(b_ap), .pteg_sec(b_as)
  );

  // stage B: masked hashes and group addresses
  logic [BW-1:0] b_q;

  hpt_stage #(.W(BW)) u_stage_b (
    .clk(clk), .rst_n(rst_n),
    .up_valid(a_valid), .up_ready(a_ready),
    .up_data({a_err, a_vpn, b_hp, b_hs, b_ap, b_as}),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(b_q)
  );

  assign {out_seg_err, out_vpn, out_hash_pri, out_hash_sec, out_pteg_pri, out_pteg_sec} = b_q;
endmodule

// File: rtl/hpt_index_gen_chk.sv
`timescale 1ns/1ps
module hpt_index_gen_chk #(
  parameter int VPN_W  = 66,
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VPN_W-1:0]  out_vpn,
  input logic [38:0]       out_hash_pri,
  input logic [38:0]       out_hash_sec,
  input logic [ADDR_W-1:0] out_pteg_pri,
  input logic [ADDR_W-1:0] out_pteg_sec,
  input logic              out_seg_err
);
  logic [2:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_vpn, out_hash_pri, out_hash_sec, out_pteg_pri, out_pteg_sec, out_seg_err}));

  assert_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> occ == 3'd2);

  assert_depth_R10: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 3'd2);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));

  assert_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hash_pri & out_hash_sec) == '0);

  assert_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pteg_pri[6:0] == out_pteg_sec[6:0]);
endmodule

bind hpt_index_gen hpt_index_gen_chk #(.VPN_W(VPN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_vpn(out_vpn),
  .out_hash_pri(out_hash_pri), .out_hash_sec(out_hash_sec),
  .out_pteg_pri(out_pteg_pri), .out_pteg_sec(out_pteg_sec), .out_seg_err(out_seg_err)
);

// File: tb/test_hpt_index_gen.sv
`timescale 1ns/1ps
module test_hpt_index_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [49:0] in_vsid = '0;
  logic [63:0] in_ea = '0;
  logic [1:0]  in_seg = '0;
  logic [5:0]  in_page_shift = 6'd12;
  logic [63:0] cfg_base = '0;
  logic [38:0] cfg_hash_mask = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [65:0] out_vpn;
  logic [38:0] out_hash_pri, out_hash_sec;
  logic [63:0] out_pteg_pri, out_pteg_sec;
  logic        out_seg_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  hpt_index_gen i_hpt_index_gen (.*);

  typedef struct packed {
    logic [63:0] vsid;
    logic [63:0] ea;
    logic [1:0]  seg;
    logic [5:0]  ps;
    logic [63:0] vpn;
    logic [38:0] hash;
    logic        err;
  } vec_t;

  localparam vec_t VECS [0:10] = '{
    '{64'h1,    64'h1000,         2'd0, 6'd12, 64'h10001,         39'h0,       1'b0},
    '{64'h3,    64'h5000,         2'd0, 6'd12, 64'h30005,         39'h6,       1'b0},
    '{64'h1,    64'h1000,         2'd1, 6'd12, 64'h10000001,      39'h2000000, 1'b0},
    '{64'h0,    64'hFFFF000,      2'd0, 6'd16, 64'hFFFF,          39'hFFF,     1'b0},
    '{64'h2,    64'h30000000,     2'd1, 6'd16, 64'h20030000,      39'h4003002, 1'b0},
    '{64'h0,    64'hF00000001000, 2'd0, 6'd12, 64'h1,             39'h1,       1'b0},
    '{64'h5,    64'hFFFF000,      2'd0, 6'd28, 64'h5FFFF,         39'h5,       1'b0},
    '{64'h4000, 64'h0,            2'd1, 6'd12, 64'h40000000000,   39'h4000,    1'b0},
    '{64'h3,    64'h5000,         2'd2, 6'd12, 64'h30005,         39'h6,       1'b1},
    '{64'h3,    64'h5000,         2'd0, 6'd8,  64'h30005,         39'h6,       1'b0},
    '{64'h1,    64'h1000,         2'd3, 6'd12, 64'h10001,         39'h0,       1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_vsid       = v.vsid[49:0];
    in_ea         = v.ea;
    in_seg        = v.seg;
    in_page_shift = v.ps;
  endtask

  task automatic check_out(input vec_t v, input logic [63:0] base, input logic [38:0] mask);
    logic [38:0] hp, hs;
    hp = v.hash & mask;
    hs = ~v.hash & mask;
    chk("R10", "out_valid due", 128'(out_valid), 128'(1'b1));
    chk(v.seg == 2'd1 ? "R2" : "R1", "vpn", 128'(out_vpn), 128'(v.vpn));
    chk(v.ps != 6'd12 ? "R5" : (v.seg == 2'd1 ? "R4" : "R3"), "hash_pri",
        128'(out_hash_pri), 128'(hp));
    chk("R6", "hash_sec", 128'(out_hash_sec), 128'(hs));
    chk("R7", "pteg_pri", 128'(out_pteg_pri), 128'(base + ({25'b0, hp} << 7)));
    chk("R7", "pteg_sec", 128'(out_pteg_sec), 128'(base + ({25'b0, hs} << 7)));
    chk("R8", "seg_err", 128'(out_seg_err), 128'(v.err));
  endtask

  task automatic run_one(input vec_t v, input logic [63:0] base, input logic [38:0] mask,
                         input bit swap_cfg);
    @(negedge clk);
    drive(v);
    cfg_base      = base;
    cfg_hash_mask = mask;
    in_valid      = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);  // accepted on the edge just passed
    in_valid = 1'b0;
    if (swap_cfg) begin  // R12: later config must not leak in
      cfg_base      = ~base;
      cfg_hash_mask = ~mask;
    end
    chk("R10", "out_valid early", 128'(out_valid), 128'(1'b0));
    @(negedge clk);
    check_out(v, base, mask);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "out_valid in reset", 128'(out_valid), 128'(1'b0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "out_valid after reset", 128'(out_valid), 128'(1'b0));
    chk("R11", "in_ready after reset", 128'(in_ready), 128'(1'b1));

    // vector table, full mask
    for (int i = 0; i < 11; i++)
      run_one(VECS[i], 64'h0000_0040_0000_0000, {39{1'b1}}, 1'b0);

    // narrow mask, non-zero base, config changed after acceptance (R6, R7, R12)
    run_one(VECS[1], 64'h1000_0000, 39'hFF, 1'b1);
    chk("R12", "pteg_pri literal", 128'(out_pteg_pri), 128'(64'h1000_0300));
    chk("R12", "pteg_sec literal", 128'(out_pteg_sec), 128'(64'h1000_7C80));
    chk("R6", "hash_sec literal", 128'(out_hash_sec), 128'(39'hF9));

    // back-pressure: two results queue, third request waits (R9, R10)
    cfg_base      = '0;
    cfg_hash_mask = {39{1'b1}};
    @(negedge clk);
    out_ready = 1'b0;
    drive(VECS[0]); in_valid = 1'b1;
    @(negedge clk);
    drive(VECS[2]);
    @(negedge clk);
    drive(VECS[4]);
    @(negedge clk);
    chk("R9", "in_ready when full", 128'(in_ready), 128'(1'b0));
    for (int k = 0; k < 3; k++) begin
      chk("R9", "held vpn", 128'(out_vpn), 128'(VECS[0].vpn));
      chk("R9", "held valid", 128'(out_valid), 128'(1'b1));
      @(negedge clk);
    end
    chk("R9", "in_ready still low", 128'(in_ready), 128'(1'b0));
    out_ready = 1'b1;  // next edge: first result leaves, third request enters
    @(negedge clk);
    in_valid = 1'b0;
    check_out(VECS[2], 64'h0, {39{1'b1}});
    @(negedge clk);
    check_out(VECS[4], 64'h0, {39{1'b1}});
    @(negedge clk);
    chk("R10", "drained", 128'(out_valid), 128'(1'b0));

    // streaming: one request per cycle, in order (R10)
    in_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      drive(VECS[k]);
      chk("R10", "in_ready streaming", 128'(in_ready), 128'(1'b1));
      if (k >= 2) check_out(VECS[k-2], 64'h0, {39{1'b1}});
      @(negedge clk);
    end
    in_valid = 1'b0;
    check_out(VECS[2], 64'h0, {39{1'b1}});
    @(negedge clk);
    check_out(VECS[3], 64'h0, {39{1'b1}});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired actual=%0d expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule